// File: doc/BRIEF.md
# Time-Multiplexed Time-of-Flight Result Readout

This block gathers time-of-flight results from a bank of per-row result queues and streams them off the chip over a small number of output lanes. The sources are split into groups of eight. Each group owns one output lane, and that lane visits the eight sources of its group one after another, one slot per clock. At 100 MHz with eight groups this carries up to 800 million results per second. Each source therefore gets a slot every eighth cycle, which matches its own result rate.

The block keeps one slot counter for all groups. In each cycle, the source of each group that owns the current slot is popped if its queue has data. The popped result goes through a fixed-depth register pipeline to the lane output as a 21-bit word: a valid flag, an 8-bit column hit pattern and a 12-bit time value. The slot number comes out next to the words, delayed so that it names the source of the word currently shown. An 8-bit column-window coordinate is sampled in every pop cycle and delayed by the same depth, so each word leaves paired with the window that was active when it was popped. In a slot with no data, the valid flag drops and the time and hit bits keep their last value, so the output pins do not toggle.

Top module: `tof_readout`

## Requirements
- R1: While `rstN` is low, `srcPop` is all zero. One clock edge in reset clears every lane word to zero, clears `slotIdx` to 0 and clears `coordOut` to 0.
- R2: The internal pop slot is 0 in the first cycle after reset is released and then goes up by one every cycle, wrapping from 7 to 0. `slotIdx` shows the pop slot of the cycle `LATENCY` cycles earlier, and reads 0 before that.
- R3: In a cycle with pop slot k, `srcPop[g*8+k]` equals `srcValid[g*8+k]` for each group g. Every other bit of `srcPop` is 0, so each group pops at most one source per cycle.
- R4: Lane word g is bits [g*21 +: 21] of `grpWord`. Bit 20 is the valid flag, bits 19:12 are the hit pattern and bits 11:0 are the time value. A valid word carries the time and hit fields of the source popped in its own group.
- R5: The valid flag of lane g is set exactly `LATENCY` cycles after a cycle in which a source of group g was popped, and is clear otherwise.
- R6: When a lane's valid flag is clear, that lane's time and hit bits keep the value they had in the previous cycle.
- R7: `coordOut` equals the `coordIn` value of the cycle `LATENCY` cycles earlier.
- R8: With every source holding data, each group delivers one valid word per cycle, which is eight results per cycle in total, with no slot lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rstN | input | 1 | Synchronous reset, active low |
| srcValid | input | 64 | Queue of each source holds a result |
| srcTof | input | 768 | Time values, 12 bits per source, source s at [s*12 +: 12] |
| srcHits | input | 512 | Column hit patterns, 8 bits per source, source s at [s*8 +: 8] |
| coordIn | input | 8 | Column-window coordinate active in this cycle |
| srcPop | output | 64 | Pop strobe to each source queue |
| slotIdx | output | 3 | Source number within the group for the words now on the lanes |
| grpWord | output | 168 | Eight 21-bit lane words |
| coordOut | output | 8 | Coordinate aligned with the lane words |

## Verification
The hardest behaviour to reach from the ports is the hold on idle slots right after a valid word, together with the coordinate pairing. Both need a lane that alternates between data and silence while the coordinate keeps changing. A sparse pattern reaches this: only one source in each of two groups holds data, so each of those lanes shows one valid word and then seven idle slots. A mixed pattern then scatters valid sources over slots and groups. The coordinate changes every cycle, and the bench sets the pipeline depth to three, so an alignment off by one cycle shows up as a wrong coordinate or slot number.

// File: rtl/tof_readout_pkg.sv
package tof_readout_pkg;

  // width of the slot number; the group size is 2**SLOT_W
  localparam int unsigned SLOT_W = 3;

  // control to datapath: which slot pops this cycle and whether popping is allowed
  typedef struct packed {
    logic              popEn;
    logic [SLOT_W-1:0] popSlot;
  } ctrlStrobe_t;

endpackage

// File: rtl/tofro_lane.sv
module tofro_lane
  import tof_readout_pkg::*;
#(
  parameter int unsigned TOF_W   = 12,
  parameter int unsigned HIT_W   = 8,
  parameter int unsigned LATENCY = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctrlStrobe_t                      strobe,
  input  logic [(1<<SLOT_W)-1:0]           laneValid,
  input  logic [(1<<SLOT_W)*TOF_W-1:0]     laneTof,
  input  logic [(1<<SLOT_W)*HIT_W-1:0]     laneHits,
  output logic [(1<<SLOT_W)-1:0]           lanePop,
  output logic [TOF_W+HIT_W:0]             laneWord
);

  localparam int unsigned GROUP_SIZE = 1 << SLOT_W;
  localparam int unsigned DATA_W     = TOF_W + HIT_W;

  logic              selValid;
  logic [DATA_W-1:0] selData;
  logic              stV [LATENCY];
  logic [DATA_W-1:0] stD [LATENCY];

  // pop only the source that owns the current slot
  always_comb begin
    for (int s = 0; s < GROUP_SIZE; s++) begin
      lanePop[s] = strobe.popEn && laneValid[s] && (strobe.popSlot == SLOT_W'(s));
    end
  end

  assign selValid = |lanePop;
  assign selData  = {laneHits[strobe.popSlot*HIT_W +: HIT_W],
                     laneTof[strobe.popSlot*TOF_W +: TOF_W]};

  // data stages load only on valid, so idle slots leave the outputs unchanged
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LATENCY; i++) begin
        stV[i] <= 1'b0;
        stD[i] <= '0;
      end
    end else begin
      stV[0] <= selValid;
      if (selValid) stD[0] <= selData;
      for (int i = 1; i < LATENCY; i++) begin
        stV[i] <= stV[i-1];
        if (stV[i-1]) stD[i] <= stD[i-1];
      end
    end
  end

  assign laneWord = {stV[LATENCY-1], stD[LATENCY-1]};

endmodule

// File: rtl/tofro_ctrl.sv
module tofro_ctrl
  import tof_readout_pkg::*;
#(
  parameter int unsigned LATENCY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  output ctrlStrobe_t       strobe,
  output logic [SLOT_W-1:0] outIdx
);

  logic [SLOT_W-1:0] slotCnt;
  logic [SLOT_W-1:0] idxPipe [LATENCY];

  always_ff @(posedge clk) begin
    if (!rstN) slotCnt <= '0;
    else       slotCnt <= slotCnt + 1'b1;
  end

  // slot number follows the words through a delay line of the data-path depth
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LATENCY; i++) idxPipe[i] <= '0;
    end else begin
      idxPipe[0] <= slotCnt;
      for (int i = 1; i < LATENCY; i++) idxPipe[i] <= idxPipe[i-1];
    end
  end

  assign strobe.popEn   = rstN;
  assign strobe.popSlot = slotCnt;
  assign outIdx         = idxPipe[LATENCY-1];

endmodule

// File: rtl/tofro_datapath.sv
module tofro_datapath
  import tof_readout_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned TOF_W      = 12,
  parameter int unsigned HIT_W      = 8,
  parameter int unsigned COORD_W    = 8,
  parameter int unsigned LATENCY    = 2
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  ctrlStrobe_t                                   strobe,
  input  logic [NUM_GROUPS*(1<<SLOT_W)-1:0]             srcValid,
  input  logic [NUM_GROUPS*(1<<SLOT_W)*TOF_W-1:0]       srcTof,
  input  logic [NUM_GROUPS*(1<<SLOT_W)*HIT_W-1:0]       srcHits,
  input  logic [COORD_W-1:0]                            coordIn,
  output logic [NUM_GROUPS*(1<<SLOT_W)-1:0]             srcPop,
  output logic [NUM_GROUPS*(TOF_W+HIT_W+1)-1:0]         grpWord,
  output logic [COORD_W-1:0]                            coordOut
);

  localparam int unsigned GROUP_SIZE = 1 << SLOT_W;
  localparam int unsigned WORD_W     = TOF_W + HIT_W + 1;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_lane
    tofro_lane #(
      .TOF_W   (TOF_W),
      .HIT_W   (HIT_W),
      .LATENCY (LATENCY)
    ) lane_i (
      .clk       (clk),
      .rstN      (rstN),
      .strobe    (strobe),
      .laneValid (srcValid[g*GROUP_SIZE +: GROUP_SIZE]),
      .laneTof   (srcTof[g*GROUP_SIZE*TOF_W +: GROUP_SIZE*TOF_W]),
      .laneHits  (srcHits[g*GROUP_SIZE*HIT_W +: GROUP_SIZE*HIT_W]),
      .lanePop   (srcPop[g*GROUP_SIZE +: GROUP_SIZE]),
      .laneWord  (grpWord[g*WORD_W +: WORD_W])
    );
  end

  // coordinate delay line, same depth as the lane pipelines
  logic [COORD_W-1:0] coordPipe [LATENCY];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LATENCY; i++) coordPipe[i] <= '0;
    end else begin
      coordPipe[0] <= coordIn;
      for (int i = 1; i < LATENCY; i++) coordPipe[i] <= coordPipe[i-1];
    end
  end

  assign coordOut = coordPipe[LATENCY-1];

endmodule

// File: rtl/tof_readout.sv
module tof_readout
  import tof_readout_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned TOF_W      = 12,
  parameter int unsigned HIT_W      = 8,
  parameter int unsigned COORD_W    = 8,
  parameter int unsigned LATENCY    = 2
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic [NUM_GROUPS*(1<<SLOT_W)-1:0]         srcValid,
  input  logic [NUM_GROUPS*(1<<SLOT_W)*TOF_W-1:0]   srcTof,
  input  logic [NUM_GROUPS*(1<<SLOT_W)*HIT_W-1:0]   srcHits,
  input  logic [COORD_W-1:0]                        coordIn,
  output logic [NUM_GROUPS*(1<<SLOT_W)-1:0]         srcPop,
  output logic [SLOT_W-1:0]                         slotIdx,
  output logic [NUM_GROUPS*(TOF_W+HIT_W+1)-1:0]     grpWord,
  output logic [COORD_W-1:0]                        coordOut
);

  ctrlStrobe_t ctrlS;

  tofro_ctrl #(
    .LATENCY (LATENCY)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (ctrlS),
    .outIdx (slotIdx)
  );

  tofro_datapath #(
    .NUM_GROUPS (NUM_GROUPS),
    .TOF_W      (TOF_W),
    .HIT_W      (HIT_W),
    .COORD_W    (COORD_W),
    .LATENCY    (LATENCY)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (ctrlS),
    .srcValid (srcValid),
    .srcTof   (srcTof),
    .srcHits  (srcHits),
    .coordIn  (coordIn),
    .srcPop   (srcPop),
    .grpWord  (grpWord),
    .coordOut (coordOut)
  );

endmodule

// File: rtl/tof_readout_checker.sv
module tof_readout_checker
  import tof_readout_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 8,
  parameter int unsigned TOF_W      = 12,
  parameter int unsigned HIT_W      = 8
) (
  input logic                                  clk,
  input logic                                  rstN,
  input logic [NUM_GROUPS*(1<<SLOT_W)-1:0]     srcPop,
  input logic [NUM_GROUPS*(TOF_W+HIT_W+1)-1:0] grpWord,
  input logic [SLOT_W-1:0]                     popSlot
);

  localparam int unsigned WORD_W = TOF_W + HIT_W + 1;

  logic                  armed;
  logic [NUM_GROUPS-1:0] validBits;

  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_vb
    assign validBits[g] = grpWord[g*WORD_W + WORD_W - 1];
  end

  // R1: a cycle in reset leaves every lane word invalid
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (validBits == '0));

  // R1: no pops while reset is held
  always_comb begin
    if (rstN === 1'b0) begin
      p_no_pop_in_reset_r1: assert (srcPop == '0);
    end
  end

  // R2: the pop slot steps by one per cycle with wrap
  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (popSlot == SLOT_W'($past(popSlot) + 1'b1)));

  // R3: at most one pop per group, so at most NUM_GROUPS pops in total
  p_pop_per_group_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(srcPop) <= NUM_GROUPS);

  // R6: idle lanes keep their data bits
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_hold
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
      (armed && !validBits[g]) |-> $stable(grpWord[g*WORD_W +: WORD_W-1]));
  end

endmodule

bind tof_readout tof_readout_checker #(
  .NUM_GROUPS (NUM_GROUPS),
  .TOF_W      (TOF_W),
  .HIT_W      (HIT_W)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .srcPop  (srcPop),
  .grpWord (grpWord),
  .popSlot (ctrlS.popSlot)
);

// File: tb/tof_readout_tb_top.sv
`timescale 1ns/1ps
module tof_readout_tb_top;

  localparam int NG  = 8;
  localparam int GS  = 8;
  localparam int NS  = NG*GS;
  localparam int TW  = 12;
  localparam int HW  = 8;
  localparam int CW  = 8;
  localparam int LAT = 3;
  localparam int WW  = TW+HW+1;
  localparam int RB  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NS-1:0]     srcValid = '0;
  logic [NS*TW-1:0]  srcTof = '0;
  logic [NS*HW-1:0]  srcHits = '0;
  logic [CW-1:0]     coordIn = '0;
  logic [NS-1:0]     srcPop;
  logic [2:0]        slotIdx;
  logic [NG*WW-1:0]  grpWord;
  logic [CW-1:0]     coordOut;

  int nChecks = 0;
  int nErr    = 0;
  int cyc     = 0;
  int validWords;
  int popsSeen;
  bit done = 1'b0;

  logic          recValid [RB][NG];
  logic [TW-1:0] recTof   [RB][NG];
  logic [HW-1:0] recHits  [RB][NG];
  logic [CW-1:0] recCoord [RB];
  logic [2:0]    recIdx   [RB];
  logic [TW-1:0] lastTof  [NG];
  logic [HW-1:0] lastHits [NG];

  always #4 clk = ~clk;

  tof_readout #(
    .NUM_GROUPS (NG), .TOF_W (TW), .HIT_W (HW), .COORD_W (CW), .LATENCY (LAT)
  ) dut_i (
    .clk (clk), .rstN (rstN), .srcValid (srcValid), .srcTof (srcTof),
    .srcHits (srcHits), .coordIn (coordIn), .srcPop (srcPop),
    .slotIdx (slotIdx), .grpWord (grpWord), .coordOut (coordOut)
  );

  function automatic logic [TW-1:0] tofF(int s, int c);
    return TW'((s*37 + c*11 + 5) % 4096);
  endfunction

  function automatic logic [HW-1:0] hitsF(int s, int c);
    return HW'(8'h01 << ((s + c) % 8)) ^ HW'(s);
  endfunction

  function automatic bit validF(int mode, int s, int c);
    case (mode)
      0: return 1'b1;
      1: return (s == 21) || (s == 56);
      2: return 1'b0;
      default: return ((s*3 + c) % 5) < 2;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic applyInputs(int mode, int c);
    for (int s = 0; s < NS; s++) begin
      srcValid[s]            = validF(mode, s, c);
      srcTof[s*TW +: TW]     = tofF(s, c);
      srcHits[s*HW +: HW]    = hitsF(s, c);
    end
    coordIn = CW'(c*29 + 7);
  endtask

  // one cycle: called just after a falling edge, returns just after the next one
  task automatic stepCycle(int mode);
    int slot;
    int r;
    logic [NS-1:0] expPop;
    applyInputs(mode, cyc);
    #1;
    slot = cyc % GS;
    expPop = '0;
    for (int s = 0; s < NS; s++) expPop[s] = validF(mode, s, cyc) && ((s % GS) == slot);
    check(srcPop == expPop, "R3", "pop vector", longint'(srcPop[31:0] ^ srcPop[63:32]),
          longint'(expPop[31:0] ^ expPop[63:32]));
    popsSeen += $countones(srcPop);
    r = cyc % RB;
    for (int g = 0; g < NG; g++) begin
      recValid[r][g] = validF(mode, g*GS + slot, cyc);
      recTof[r][g]   = tofF(g*GS + slot, cyc);
      recHits[r][g]  = hitsF(g*GS + slot, cyc);
    end
    recCoord[r] = coordIn;
    recIdx[r]   = 3'(slot);
    if (cyc >= LAT) begin
      r = (cyc - LAT) % RB;
      check(slotIdx == recIdx[r], "R2", "slotIdx", slotIdx, recIdx[r]);
      check(coordOut == recCoord[r], "R7", "coordOut", coordOut, recCoord[r]);
      for (int g = 0; g < NG; g++) begin
        logic [WW-1:0] w;
        w = grpWord[g*WW +: WW];
        check(w[WW-1] == recValid[r][g], "R5", $sformatf("valid lane %0d", g), w[WW-1], recValid[r][g]);
        if (w[WW-1]) validWords++;
        if (recValid[r][g]) begin
          lastTof[g]  = recTof[r][g];
          lastHits[g] = recHits[r][g];
          check({w[TW+HW-1:TW], w[TW-1:0]} == {lastHits[g], lastTof[g]}, "R4",
                $sformatf("data lane %0d", g), w[TW+HW-1:0], {lastHits[g], lastTof[g]});
        end else begin
          check({w[TW+HW-1:TW], w[TW-1:0]} == {lastHits[g], lastTof[g]}, "R6",
                $sformatf("held data lane %0d", g), w[TW+HW-1:0], {lastHits[g], lastTof[g]});
        end
      end
    end else begin
      check(slotIdx == 3'd0, "R2", "slotIdx before first word", slotIdx, 0);
      for (int g = 0; g < NG; g++) begin
        check(grpWord[g*WW + WW-1] == 1'b0, "R5", $sformatf("early valid lane %0d", g),
              grpWord[g*WW + WW-1], 0);
      end
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0;
    applyInputs(0, 3);
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      #1;
      check(srcPop == '0, "R1", "pop in reset", longint'($countones(srcPop)), 0);
      check(grpWord == '0, "R1", "words in reset", longint'($countones(grpWord)), 0);
      check(slotIdx == 3'd0, "R1", "slotIdx in reset", slotIdx, 0);
      check(coordOut == '0, "R1", "coordOut in reset", coordOut, 0);
      @(negedge clk);
    end
    rstN = 1'b1;
    cyc = 0;
    for (int g = 0; g < NG; g++) begin
      lastTof[g]  = '0;
      lastHits[g] = '0;
    end
  endtask

  task automatic testFullLoad();
    int n;
    n = 24;
    validWords = 0;
    popsSeen = 0;
    for (int k = 0; k < n; k++) stepCycle(0);
    check(popsSeen == n*NG, "R8", "pops under full load", popsSeen, n*NG);
    check(validWords == (n-LAT)*NG, "R8", "words under full load", validWords, (n-LAT)*NG);
  endtask

  task automatic testSparse();
    validWords = 0;
    popsSeen = 0;
    for (int k = 0; k < 32; k++) stepCycle(1);
  endtask

  task automatic testIdle();
    for (int k = 0; k < 12; k++) stepCycle(2);
  endtask

  task automatic testMixed();
    for (int k = 0; k < 40; k++) stepCycle(3);
  endtask

  initial begin
    #(8*200000);
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    testReset();
    testFullLoad();
    testSparse();
    testIdle();
    testMixed();
    testReset();
    testMixed();
    testSparse();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule